// File: doc/BRIEF.md
# Programmable Parallel Display Bus Engine

This block is the bus-side engine for an external display controller that keeps its own frame memory and listens on an 8080-style parallel bus. A requester asks for one access at a time: a command write, a parameter or pixel-data write, or a read. The engine then runs one bus cycle, driving chip select, write strobe, read strobe, the data/command select line and the data lanes. It reports when the cycle ends and returns the word it read.

Every strobe edge is placed by a tick count from two 32-bit timing words. A separate access tick sets when read data is captured. Ticks come from the block clock divided by 1 or 2. The engine checks the programmed ordering rules on every cycle. While they are broken it raises a configuration error and refuses all work. The bus moves 16 bits per access, or 8 bits on the low lanes.

Top module: `pbus_engine`

## Requirements
- R1: The edge word `cfg_edges` holds six fields: CS assert tick [3:0], CS release tick [9:4], WE assert tick [13:10], WE release tick [19:14], RE assert tick [23:20] and RE release tick [29:24]. The cycle word `cfg_cycles` holds the write cycle length [5:0], the read cycle length [11:6] and the minimum CS pulse length [17:12]. Bits above these fields are ignored.
- R2: Tick k of a cycle covers the clocks from k*D to (k+1)*D-1 after the accepting edge, where D is `cfg_div`. Only D = 1 and D = 2 are legal, and any other value raises `cfg_err`.
- R3: CS, WE and RE are active low and high when idle. Each one is low exactly during the ticks t with assert <= t < release, inside the cycle. WE moves only on writes and RE moves only on reads.
- R4: A cycle lasts E ticks. E is the larger of the CS pulse length and the cycle length for the kind (read or write). `busy` is high for E*D clocks, and `done` is high for the single clock after that.
- R5: A request is accepted only when `req_valid` is high, `busy` is low, `cfg_err` is low and `req_kind` is 0 (command), 1 (data write) or 2 (read). Kind 3 and any request made while busy are dropped.
- R6: `cfg_err` is high unless all of these hold: WE release > WE assert, RE release > RE assert, CS release > CS assert, CS release >= both WE and RE release, write length >= WE release, read length >= RE release, and RE assert < access tick <= read length. While it is high, no cycle starts.
- R7: `bus_dc` is low during a command write, high during data writes and reads, and high when idle. It does not change within a cycle.
- R8: During a write, `bus_oe` is high and `bus_dout` holds the request word for the whole cycle. During a read or when idle, `bus_oe` is low and `bus_dout` is zero.
- R9: On a read, `rd_data` takes `bus_din` as it stands at the clock edge where the tick count reaches `cfg_access`. It then holds that value through later writes until the next read.
- R10: With `cfg_wide` low, only lanes [7:0] carry data. The upper write lanes are zero and the upper read bits are returned as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_edges | input | 32 | Assert/release ticks of CS, WE, RE |
| cfg_cycles | input | 32 | Write length, read length, CS pulse length |
| cfg_access | input | 6 | Read capture tick |
| cfg_div | input | 2 | Tick prescaler, 1 or 2 |
| cfg_wide | input | 1 | 1 = 16-bit lanes, 0 = 8-bit lanes |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 command, 1 data write, 2 read |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| cfg_err | output | 1 | Timing words break an ordering rule |
| rd_data | output | 16 | Last captured read word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Data/command select |
| bus_oe | output | 1 | Data lane output enable |
| bus_dout | output | 16 | Data lanes driven out |
| bus_din | input | 16 | Data lanes sampled in |

## Verification
The assertions assume that the configuration inputs stay still while `busy` is high. They also assume the prescaler bound holds only under a legal divider. The stimulus reloads the timing words and divider only between cycles, at least one clock before a request. A drifting configuration mid-cycle is never driven, so a check failure always points at the engine, never at a changing input. The read lanes show the true word only on the single clock before the capture edge and the inverted word at every other time. This pins the capture to its programmed tick.

// File: rtl/pbus_pkg.sv
// Shared widths, access kinds and decoded timing record for the parallel
// display bus engine. Timing field widths are fixed by the timing word format.
package pbus_pkg;

    localparam int ON_W  = 4;   // width of an assert-tick field
    localparam int OFF_W = 6;   // width of release / length fields and tick counter

    typedef logic [OFF_W-1:0] tick_t;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_DATA = 2'd1,
        KIND_READ = 2'd2,
        KIND_NONE = 2'd3
    } kind_e;

    typedef struct packed {
        tick_t cs_on;
        tick_t cs_off;
        tick_t we_on;
        tick_t we_off;
        tick_t re_on;
        tick_t re_off;
        tick_t wr_len;
        tick_t rd_len;
        tick_t cs_min;
        tick_t access;
    } timing_t;

endpackage

// File: rtl/pbus_cfg_check.sv
// Decodes the two timing words into a tick record and judges whether the
// programmed values obey the ordering rules. Purely combinational; assumes the
// words are held steady by the owner while a cycle is running.
module pbus_cfg_check
    import pbus_pkg::*;
#(
    parameter int DIV_W   = 2,
    parameter int MAX_DIV = 2
) (
    input  logic [31:0]      edge_word,
    input  logic [31:0]      cycle_word,
    input  tick_t            access,
    input  logic [DIV_W-1:0] div,
    output timing_t          tim,
    output logic             cfg_err
);

    logic unused_bits;
    logic div_ok;
    logic order_ok;

    assign unused_bits = ^{edge_word[31:30], cycle_word[31:18]};

    // Field extraction: assert ticks are zero-extended to the counter width.
    always_comb begin
        tim.cs_on  = tick_t'(edge_word[3:0]);
        tim.cs_off = edge_word[9:4];
        tim.we_on  = tick_t'(edge_word[13:10]);
        tim.we_off = edge_word[19:14];
        tim.re_on  = tick_t'(edge_word[23:20]);
        tim.re_off = edge_word[29:24];
        tim.wr_len = cycle_word[5:0];
        tim.rd_len = cycle_word[11:6];
        tim.cs_min = cycle_word[17:12];
        tim.access = access;
    end

    // Rule evaluation: legal divider plus every edge ordering constraint.
    always_comb begin
        div_ok   = (div >= DIV_W'(1)) && (div <= DIV_W'(MAX_DIV));
        order_ok = (tim.we_off > tim.we_on) &&
                   (tim.re_off > tim.re_on) &&
                   (tim.cs_off > tim.cs_on) &&
                   (tim.cs_off >= tim.we_off) &&
                   (tim.cs_off >= tim.re_off) &&
                   (tim.wr_len >= tim.we_off) &&
                   (tim.rd_len >= tim.re_off) &&
                   (tim.access > tim.re_on) &&
                   (tim.access <= tim.rd_len);
        cfg_err  = !(div_ok && order_ok);
    end

endmodule

// File: rtl/pbus_tick_gen.sv
// Prescaler that turns the block clock into bus ticks. Restarts on every
// accepted request so tick 0 begins on the accepting edge; only counts while a
// cycle runs. Assumes div is a legal value whenever run is high.
module pbus_tick_gen #(
    parameter int DIV_W   = 2,
    parameter int MAX_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int CNT_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [CNT_W-1:0] pcnt_q;

    assign tick = run && (DIV_W'(pcnt_q) == div - DIV_W'(1));

    // Clock counter within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= tick ? '0 : pcnt_q + CNT_W'(1);
        end
    end

    assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (DIV_W'(pcnt_q) < div));

endmodule

// File: rtl/pbus_cycle_fsm.sv
// Runs one bus cycle: tick counter, end-of-cycle detection, strobe windows,
// data/command select, write lane drive and read capture. Assumes start is
// only raised while idle and that the timing record is steady during a cycle.
module pbus_cycle_fsm
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  kind_e             kind_in,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wide,
    input  timing_t           tim,
    input  logic              tick,
    input  logic [DATA_W-1:0] din,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              cs_n,
    output logic              we_n,
    output logic              re_n,
    output logic              dc,
    output logic              oe,
    output logic [DATA_W-1:0] dout
);

    localparam int LANE_W = DATA_W / 2;

    logic              active_q;
    logic              done_q;
    tick_t             t_q;
    tick_t             end_q;
    kind_e             kind_q;
    logic              wide_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_q;
    tick_t             t_inc;
    tick_t             len_sel;
    tick_t             end_next;
    logic              is_read;

    function automatic logic [DATA_W-1:0] lane_fit(input logic [DATA_W-1:0] v,
                                                   input logic w);
        return w ? v : {{(DATA_W-LANE_W){1'b0}}, v[LANE_W-1:0]};
    endfunction

    // Cycle length for the incoming request: kind length stretched by CS minimum.
    always_comb begin
        len_sel  = (kind_in == KIND_READ) ? tim.rd_len : tim.wr_len;
        end_next = (len_sel > tim.cs_min) ? len_sel : tim.cs_min;
        t_inc    = t_q + tick_t'(1);
        is_read  = (kind_q == KIND_READ);
    end

    // Cycle state: start, advance per tick, capture read data, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            t_q      <= '0;
            end_q    <= '0;
            kind_q   <= KIND_CMD;
            wide_q   <= 1'b1;
            data_q   <= '0;
            rd_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                t_q      <= '0;
                end_q    <= end_next;
                kind_q   <= kind_in;
                wide_q   <= wide;
                data_q   <= lane_fit(wdata, wide);
            end else if (active_q && tick) begin
                if (is_read && (t_inc == tim.access)) begin
                    rd_q <= lane_fit(din, wide_q);
                end
                if (t_inc == end_q) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                    t_q      <= '0;
                end else begin
                    t_q <= t_inc;
                end
            end
        end
    end

    // Bus pin decode from the tick counter and latched request.
    always_comb begin
        cs_n = !(active_q && (t_q >= tim.cs_on) && (t_q < tim.cs_off));
        we_n = !(active_q && !is_read && (t_q >= tim.we_on) && (t_q < tim.we_off));
        re_n = !(active_q && is_read && (t_q >= tim.re_on) && (t_q < tim.re_off));
        dc   = active_q ? (kind_q != KIND_CMD) : 1'b1;
        oe   = active_q && !is_read;
        dout = oe ? data_q : '0;
    end

    assign active  = active_q;
    assign done    = done_q;
    assign rd_data = rd_q;

    assert_tick_below_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (t_q < end_q));

    assert_dc_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |=> (!active_q || $stable(dc)));

    assert_dout_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |=> (!active_q || $stable(dout)));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_q && tick && is_read) |=> $stable(rd_q));

endmodule

// File: rtl/pbus_engine.sv
// Top of the parallel display bus engine. Gates requests against busy, the
// configuration check and the kind code, then hands them to the cycle FSM
// paced by the tick prescaler. Assumes configuration inputs only change while
// busy is low.
module pbus_engine
    import pbus_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 2,
    parameter int MAX_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_edges,
    input  logic [31:0]       cfg_cycles,
    input  logic [OFF_W-1:0]  cfg_access,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_wide,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic              bus_re_n,
    output logic              bus_dc,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din
);

    timing_t tim;
    kind_e   kind;
    logic    start;
    logic    tick;

    // Request gate: idle, legal timing, legal kind.
    always_comb begin
        kind  = kind_e'(req_kind);
        start = req_valid && !busy && !cfg_err && (kind != KIND_NONE);
    end

    pbus_cfg_check #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) u_cfg (
        .edge_word (cfg_edges),
        .cycle_word(cfg_cycles),
        .access    (cfg_access),
        .div       (cfg_div),
        .tim       (tim),
        .cfg_err   (cfg_err)
    );

    pbus_tick_gen #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(start),
        .run    (busy),
        .div    (cfg_div),
        .tick   (tick)
    );

    pbus_cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .kind_in(kind),
        .wdata  (req_wdata),
        .wide   (cfg_wide),
        .tim    (tim),
        .tick   (tick),
        .din    (bus_din),
        .active (busy),
        .done   (done),
        .rd_data(rd_data),
        .cs_n   (bus_cs_n),
        .we_n   (bus_we_n),
        .re_n   (bus_re_n),
        .dc     (bus_dc),
        .oe     (bus_oe),
        .dout   (bus_dout)
    );

    assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_refuse_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !busy) |=> !busy);

    assert_refuse_bad_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (req_kind == 2'd3)) |=> !busy);

endmodule

// File: tb/test_pbus_engine.sv
`timescale 1ns/1ps
module test_pbus_engine;

    typedef struct packed {
        logic [1:0]  div;
        logic        wide;
        logic [1:0]  kind;
        logic [3:0]  cs_on;
        logic [5:0]  cs_off;
        logic [3:0]  we_on;
        logic [5:0]  we_off;
        logic [3:0]  re_on;
        logic [5:0]  re_off;
        logic [5:0]  wlen;
        logic [5:0]  rlen;
        logic [5:0]  csmin;
        logic [5:0]  acc;
        logic [15:0] wdata;
        logic [15:0] din;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b1, 2'd0, 4'd0, 6'd5,  4'd1, 6'd4, 4'd1, 6'd4,  6'd6, 6'd6,  6'd0, 6'd2,  16'hA5C3, 16'h1111},
        '{2'd2, 1'b1, 2'd1, 4'd1, 6'd6,  4'd2, 6'd5, 4'd2, 6'd5,  6'd7, 6'd7,  6'd3, 6'd3,  16'h5A3C, 16'h2222},
        '{2'd1, 1'b1, 2'd2, 4'd0, 6'd7,  4'd1, 6'd3, 4'd2, 6'd6,  6'd5, 6'd8,  6'd0, 6'd4,  16'h0000, 16'hBEEF},
        '{2'd2, 1'b1, 2'd2, 4'd1, 6'd8,  4'd0, 6'd2, 4'd3, 6'd7,  6'd4, 6'd9,  6'd2, 6'd5,  16'h0000, 16'hCAFE},
        '{2'd1, 1'b0, 2'd0, 4'd2, 6'd9,  4'd3, 6'd8, 4'd1, 6'd2,  6'd9, 6'd4,  6'd0, 6'd2,  16'h12F7, 16'h0000},
        '{2'd2, 1'b0, 2'd1, 4'd0, 6'd4,  4'd0, 6'd3, 4'd0, 6'd4,  6'd4, 6'd5,  6'd0, 6'd1,  16'hFF81, 16'h0000},
        '{2'd1, 1'b0, 2'd2, 4'd0, 6'd6,  4'd1, 6'd2, 4'd1, 6'd5,  6'd3, 6'd6,  6'd0, 6'd3,  16'h0000, 16'h9D42},
        '{2'd1, 1'b1, 2'd1, 4'd0, 6'd3,  4'd1, 6'd2, 4'd1, 6'd2,  6'd3, 6'd3,  6'd7, 6'd2,  16'h0F0F, 16'h0000},
        '{2'd2, 1'b0, 2'd2, 4'd0, 6'd12, 4'd0, 6'd1, 4'd2, 6'd10, 6'd2, 6'd11, 6'd0, 6'd11, 16'h0000, 16'h77AB}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_edges;
    logic [31:0] cfg_cycles;
    logic [5:0]  cfg_access;
    logic [1:0]  cfg_div;
    logic        cfg_wide;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_wdata;
    logic        busy, done, cfg_err;
    logic [15:0] rd_data;
    logic        bus_cs_n, bus_we_n, bus_re_n, bus_dc, bus_oe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_rd = 16'h0000;

    always #4 clk = ~clk;

    pbus_engine i_pbus_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_edges(cfg_edges), .cfg_cycles(cfg_cycles), .cfg_access(cfg_access),
        .cfg_div(cfg_div), .cfg_wide(cfg_wide),
        .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
        .busy(busy), .done(done), .cfg_err(cfg_err), .rd_data(rd_data),
        .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n),
        .bus_dc(bus_dc), .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic load(input vec_t v);
        cfg_edges  = {2'b00, v.re_off, v.re_on, v.we_off, v.we_on, v.cs_off, v.cs_on};
        cfg_cycles = {14'h3ABC, v.csmin, v.rlen, v.wlen};
        cfg_access = v.acc;
        cfg_div    = v.div;
        cfg_wide   = v.wide;
    endtask

    // Run one access and compare every clock of it against the tick formulas.
    task automatic run_access(input vec_t v, input bit poke);
        int div   = int'(v.div);
        int klen  = (v.kind == 2'd2) ? int'(v.rlen) : int'(v.wlen);
        int endt  = (klen > int'(v.csmin)) ? klen : int'(v.csmin);
        int span  = endt * div;
        bit is_wr = (v.kind != 2'd2);
        logic [15:0] exp_dout = v.wide ? v.wdata : {8'h00, v.wdata[7:0]};
        logic [15:0] exp_rd   = v.wide ? v.din   : {8'h00, v.din[7:0]};
        bit s_ok = 1, l_ok = 1, d_ok = 1, w_ok = 1;
        logic [31:0] s_got = 0, s_exp = 0, l_got = 0, l_exp = 0;
        logic [31:0] d_got = 0, d_exp = 0, w_got = 0, w_exp = 0;
        load(v);
        bus_din = ~v.din;
        @(negedge clk);
        check(cfg_err == 1'b0, "R6 legal vector flagged", {31'd0, cfg_err}, 32'd0);
        req_valid = 1'b1;
        req_kind  = v.kind;
        req_wdata = v.wdata;
        for (int n = 0; n <= span; n++) begin
            @(negedge clk);
            if (n == 0) req_valid = 1'b0;
            if (n < span) begin
                int k = n / div;
                logic ecs, ewe, ere;
                ecs = !(k >= int'(v.cs_on) && k < int'(v.cs_off));
                ewe = is_wr ? !(k >= int'(v.we_on) && k < int'(v.we_off)) : 1'b1;
                ere = !is_wr ? !(k >= int'(v.re_on) && k < int'(v.re_off)) : 1'b1;
                if (s_ok && {bus_cs_n, bus_we_n, bus_re_n} != {ecs, ewe, ere}) begin
                    s_ok = 0; s_got = {n[23:0], 5'd0, bus_cs_n, bus_we_n, bus_re_n};
                    s_exp = {n[23:0], 5'd0, ecs, ewe, ere};
                end
                if (l_ok && {busy, done} != 2'b10) begin
                    l_ok = 0; l_got = {n[29:0], busy, done}; l_exp = {n[29:0], 2'b10};
                end
                if (d_ok && bus_dc != (v.kind != 2'd0)) begin
                    d_ok = 0; d_got = {n[30:0], bus_dc}; d_exp = {n[30:0], v.kind != 2'd0};
                end
                if (w_ok && ({bus_oe, bus_dout} != {is_wr, is_wr ? exp_dout : 16'h0})) begin
                    w_ok = 0; w_got = {15'd0, bus_oe, bus_dout};
                    w_exp = {15'd0, is_wr, is_wr ? exp_dout : 16'h0};
                end
            end else if (l_ok && {busy, done} != 2'b01) begin
                l_ok = 0; l_got = {n[29:0], busy, done}; l_exp = {n[29:0], 2'b01};
            end
            if (poke && n == 1) begin
                req_valid = 1'b1;
                req_kind  = (v.kind == 2'd0) ? 2'd1 : 2'd0;
                req_wdata = ~v.wdata;
            end
            if (poke && n == 2) req_valid = 1'b0;
            bus_din = (n == int'(v.acc) * div - 1) ? v.din : ~v.din;
        end
        @(negedge clk);
        if (l_ok && {busy, done} != 2'b00) begin
            l_ok = 0; l_got = {30'd0, busy, done}; l_exp = 32'd0;
        end
        check(s_ok, "R1 R2 R3 strobe edge (tick, cs/we/re)", s_got, s_exp);
        check(l_ok, "R4 cycle length / done", l_got, l_exp);
        check(d_ok, "R7 data/command select", d_got, d_exp);
        check(w_ok, v.wide ? "R8 write lanes" : "R8 R10 narrow write lanes", w_got, w_exp);
        if (!is_wr) begin
            check(rd_data == exp_rd, v.wide ? "R9 read capture" : "R9 R10 narrow read capture",
                  {16'd0, rd_data}, {16'd0, exp_rd});
            last_rd = exp_rd;
        end else begin
            check(rd_data == last_rd, "R9 read word held across write",
                  {16'd0, rd_data}, {16'd0, last_rd});
        end
        if (poke) begin
            @(negedge clk);
            check(busy == 1'b0 && bus_cs_n == 1'b1, "R5 request while busy dropped",
                  {30'd0, busy, bus_cs_n}, 32'd1);
        end
    endtask

    // Hold a request against a refused state and confirm no cycle starts.
    task automatic expect_refused(input string tag, input logic [1:0] kind);
        req_valid = 1'b1;
        req_kind  = kind;
        req_wdata = 16'h1234;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b0 && bus_cs_n == 1'b1 && bus_oe == 1'b0, tag,
              {29'd0, busy, bus_cs_n, bus_oe}, 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t bad;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_kind = 2'd0;
        req_wdata = 16'h0;
        bus_din = 16'h0;
        load(VECS[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: idle pins high, lanes quiet (R3, R7, R8, R9).
        check({bus_cs_n, bus_we_n, bus_re_n} == 3'b111, "R3 idle strobes after reset",
              {29'd0, bus_cs_n, bus_we_n, bus_re_n}, 32'd7);
        check({busy, done, bus_oe, bus_dc} == 4'b0001 && bus_dout == 16'h0,
              "R8 R7 idle lanes after reset", {12'd0, busy, done, bus_oe, bus_dc, bus_dout},
              32'h0001_0000);
        check(rd_data == 16'h0, "R9 read word after reset", {16'd0, rd_data}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_access(VECS[i], i == 1);
        end

        // Divider legality (R2).
        load(VECS[0]);
        cfg_div = 2'd3;
        @(negedge clk);
        check(cfg_err == 1'b1, "R2 divider 3 rejected", {31'd0, cfg_err}, 32'd1);
        cfg_div = 2'd0;
        @(negedge clk);
        check(cfg_err == 1'b1, "R2 divider 0 rejected", {31'd0, cfg_err}, 32'd1);
        expect_refused("R6 request refused with bad divider", 2'd1);

        // Ordering violations (R6).
        bad = VECS[0];
        bad.we_off = 6'd1;
        load(bad);
        @(negedge clk);
        check(cfg_err == 1'b1, "R6 WE release not after assert", {31'd0, cfg_err}, 32'd1);
        expect_refused("R6 request refused with bad WE order", 2'd0);
        bad = VECS[2];
        bad.cs_off = 6'd5;
        load(bad);
        @(negedge clk);
        check(cfg_err == 1'b1, "R6 CS released before RE", {31'd0, cfg_err}, 32'd1);
        bad = VECS[2];
        bad.acc = 6'd2;
        load(bad);
        @(negedge clk);
        check(cfg_err == 1'b1, "R6 access tick not after RE assert", {31'd0, cfg_err}, 32'd1);
        bad = VECS[2];
        bad.acc = 6'd9;
        load(bad);
        @(negedge clk);
        check(cfg_err == 1'b1, "R6 access tick past read length", {31'd0, cfg_err}, 32'd1);

        // Kind 3 refused with legal timing (R5).
        load(VECS[0]);
        @(negedge clk);
        expect_refused("R5 kind 3 refused", 2'd3);

        // Engine recovers once legal values return.
        run_access(VECS[4], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule